// File: doc/BRIEF.md
# Horizontal Pulse and Sandcastle Generator

This block turns one horizontal reference edge per video line into the set of line-rate timing pulses a picture-in-picture processing path needs: a horizontal drive (HD) pulse, a burst/clamp gate pulse and a horizontal blanking pulse. It also merges these with an externally supplied vertical blanking level into a three-level sandcastle code. The code is delivered as a 2-bit value; turning it into analog levels is left to the pad or DAC stage that follows.

All offsets and widths are set as durations in picoseconds and converted into clock ticks for the configured clock period when the block is elaborated. The line position is measured from the most recent rising edge of the reference. Two static control inputs move pulses. One advances the gate pulse by 200 ns. The other moves the HD pulse from the reference edge to the start of horizontal blanking, so that HD lines up with the sandcastle timing. A reference edge that arrives before the current line has finished restarts the line and cuts short any pulse that is in progress.

Top module: `hpulse_sandcastle_gen`

## Requirements
- R1: After reset, and until the first rising reference edge, `hd_o`, `gate_o` and `hblank_o` are low, and `sc_code_o` shows only the vertical blanking level (01 when `vblank_i` is high, 00 when it is low).
- R2: With `hd_alt_i` low, `hd_o` is high for HD_W ticks. Tick 0 is the first clock cycle after the edge on which the rising reference edge is sampled.
- R3: With `hd_alt_i` high, `hd_o` is high from tick BLK_START for HD_W ticks, and is low at tick 0.
- R4: With `gate_adv_i` low, `gate_o` is high from tick GATE_START for GATE_W ticks.
- R5: With `gate_adv_i` high, `gate_o` is high from tick GATE_START−GATE_ADV for GATE_W ticks.
- R6: `hblank_o` is high from tick BLK_START for BLK_W ticks.
- R7: `sc_code_o` is prioritised as follows: 11 when the gate is active; otherwise 10 during horizontal blanking; otherwise 01 when `vblank_i` is high; otherwise 00.
- R8: A rising reference edge in the middle of a line restarts the line at tick 0, and every pulse immediately follows the new line position, which truncates any pulse in progress.
- R9: Without a new reference edge, the line position stops at the line limit and does not wrap, so no pulse recurs.
- R10: Only a rising edge of `href_i` counts as a reference. Holding the input high does not restart the line.
- R11: Each tick count is the duration divided by the clock period, rounded to the nearest tick (HD 1.8 µs, gate start 3.0 µs, gate width 2.0 µs, advance 200 ns, blanking start 4.4 µs, blanking width 11.5 µs).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| href_i | input | 1 | Horizontal reference; its rising edge starts a line |
| hd_alt_i | input | 1 | 1 places the HD pulse at the blanking start |
| gate_adv_i | input | 1 | 1 advances the gate pulse by 200 ns |
| vblank_i | input | 1 | Vertical blanking level merged into the sandcastle code |
| hd_o | output | 1 | Horizontal drive pulse |
| gate_o | output | 1 | Burst/clamp gate pulse |
| hblank_o | output | 1 | Horizontal blanking pulse |
| sc_code_o | output | 2 | Sandcastle code: 11 gate, 10 horizontal blank, 01 vertical blank, 00 none |

## Verification
The bench builds the block with a 50 ns clock-period parameter, so every offset becomes a small tick count: HD 36, gate 60 for 40 (56 when advanced), blanking 88 for 230, and a 1400-tick line limit. With these counts, whole lines, the gate/blanking overlap (ticks 88 to 99, where the priority decides the code), a restart in the middle of the gate pulse and the saturated line end can all be checked tick by tick in a few thousand cycles.

// File: rtl/hpg_pkg.sv
package hpg_pkg;

  typedef enum logic [1:0] {
    SC_NONE = 2'b00,
    SC_VBLK = 2'b01,
    SC_HBLK = 2'b10,
    SC_GATE = 2'b11
  } sc_code_e;

  // duration in ps -> clock ticks, rounded to nearest
  function automatic int unsigned ps_to_ticks(input int unsigned dur_ps,
                                              input int unsigned clk_ps);
    return (dur_ps + clk_ps / 2) / clk_ps;
  endfunction

  // true when pos lies in [start, start+len)
  function automatic logic in_window(input int unsigned pos,
                                     input int unsigned start,
                                     input int unsigned len);
    return (pos >= start) && (pos < start + len);
  endfunction

endpackage

// File: rtl/hpg_ref_edge.sv
module hpg_ref_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_i,
  output logic edge_o
);
  logic ref_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_q <= 1'b0;
    else        ref_q <= ref_i;
  end

  assign edge_o = ref_i & ~ref_q;
endmodule

// File: rtl/hpg_line_cnt.sv
module hpg_line_cnt #(
  parameter int unsigned CNT_W   = 14,
  parameter int unsigned CNT_MAX = 14000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             run_o
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_o <= '0;
      run_o <= 1'b0;
    end else if (restart_i) begin
      cnt_o <= '0;
      run_o <= 1'b1;
    end else if (run_o && cnt_o != LIMIT) begin
      cnt_o <= cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/hpg_window.sv
module hpg_window
  import hpg_pkg::*;
#(
  parameter int unsigned CNT_W = 14
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             run_i,
  input  logic [31:0]      start_i,
  input  logic [31:0]      len_i,
  output logic             active_o
);
  assign active_o = run_i && in_window(32'(cnt_i), start_i, len_i);
endmodule

// File: rtl/hpg_sc_enc.sv
module hpg_sc_enc
  import hpg_pkg::*;
(
  input  logic     gate_i,
  input  logic     hblank_i,
  input  logic     vblank_i,
  output sc_code_e code_o
);
  always_comb begin
    if (gate_i)        code_o = SC_GATE;
    else if (hblank_i) code_o = SC_HBLK;
    else if (vblank_i) code_o = SC_VBLK;
    else               code_o = SC_NONE;
  end
endmodule

// File: rtl/hpulse_sandcastle_gen.sv
module hpulse_sandcastle_gen
  import hpg_pkg::*;
#(
  parameter int unsigned CLK_PS        = 5000,
  parameter int unsigned HD_W_PS       = 1_800_000,
  parameter int unsigned GATE_START_PS = 3_000_000,
  parameter int unsigned GATE_W_PS     = 2_000_000,
  parameter int unsigned GATE_ADV_PS   = 200_000,
  parameter int unsigned BLK_START_PS  = 4_400_000,
  parameter int unsigned BLK_W_PS      = 11_500_000,
  parameter int unsigned LINE_MAX_PS   = 70_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       href_i,
  input  logic       hd_alt_i,
  input  logic       gate_adv_i,
  input  logic       vblank_i,
  output logic       hd_o,
  output logic       gate_o,
  output logic       hblank_o,
  output logic [1:0] sc_code_o
);
  localparam int unsigned HD_W       = ps_to_ticks(HD_W_PS, CLK_PS);
  localparam int unsigned GATE_START = ps_to_ticks(GATE_START_PS, CLK_PS);
  localparam int unsigned GATE_W     = ps_to_ticks(GATE_W_PS, CLK_PS);
  localparam int unsigned GATE_ADV   = ps_to_ticks(GATE_ADV_PS, CLK_PS);
  localparam int unsigned BLK_START  = ps_to_ticks(BLK_START_PS, CLK_PS);
  localparam int unsigned BLK_W      = ps_to_ticks(BLK_W_PS, CLK_PS);
  localparam int unsigned CNT_MAX    = ps_to_ticks(LINE_MAX_PS, CLK_PS);
  localparam int unsigned CNT_W      = $clog2(CNT_MAX + 1);
  localparam int unsigned GATE_EARLY = (GATE_ADV > GATE_START) ? 0 : GATE_START - GATE_ADV;
  localparam int unsigned N_WIN      = 3;

  // window indices
  localparam int unsigned W_HD = 0;
  localparam int unsigned W_GT = 1;
  localparam int unsigned W_HB = 2;

  logic             ref_edge;
  logic [CNT_W-1:0] line_cnt;
  logic             line_run;
  logic [31:0]      win_start [N_WIN];
  logic [31:0]      win_len   [N_WIN];
  logic [N_WIN-1:0] win_act;
  sc_code_e         sc_code;

  hpg_ref_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .ref_i (href_i),
    .edge_o(ref_edge)
  );

  hpg_line_cnt #(.CNT_W(CNT_W), .CNT_MAX(CNT_MAX)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart_i(ref_edge),
    .cnt_o    (line_cnt),
    .run_o    (line_run)
  );

  always_comb begin
    win_start[W_HD] = hd_alt_i ? 32'(BLK_START) : 32'd0;
    win_len[W_HD]   = 32'(HD_W);
    win_start[W_GT] = gate_adv_i ? 32'(GATE_EARLY) : 32'(GATE_START);
    win_len[W_GT]   = 32'(GATE_W);
    win_start[W_HB] = 32'(BLK_START);
    win_len[W_HB]   = 32'(BLK_W);
  end

  for (genvar g = 0; g < N_WIN; g++) begin : g_win
    hpg_window #(.CNT_W(CNT_W)) u_win (
      .cnt_i   (line_cnt),
      .run_i   (line_run),
      .start_i (win_start[g]),
      .len_i   (win_len[g]),
      .active_o(win_act[g])
    );
  end

  assign hd_o     = win_act[W_HD];
  assign gate_o   = win_act[W_GT];
  assign hblank_o = win_act[W_HB];

  hpg_sc_enc u_enc (
    .gate_i  (gate_o),
    .hblank_i(hblank_o),
    .vblank_i(vblank_i),
    .code_o  (sc_code)
  );

  assign sc_code_o = sc_code;
endmodule

// File: rtl/hpg_checker.sv
module hpg_checker #(
  parameter int unsigned CNT_W   = 14,
  parameter int unsigned CNT_MAX = 14000
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ref_edge,
  input logic [CNT_W-1:0] cnt,
  input logic             run,
  input logic             hd_alt,
  input logic             vblank,
  input logic             hd,
  input logic             gate,
  input logic             hblank,
  input logic [1:0]       sc_code
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(CNT_MAX);

  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!hd && !gate && !hblank));

  p_hd_lead_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_edge && !hd_alt) |=> (hd || hd_alt));

  p_code_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    gate |-> sc_code == 2'b11);

  p_code_hblank_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hblank && !gate) |-> sc_code == 2'b10);

  p_code_vblank_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!hblank && !gate && vblank) |-> sc_code == 2'b01);

  p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ref_edge |=> (cnt == '0 && run));

  p_no_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == LIMIT && !ref_edge) |=> cnt == LIMIT);
endmodule

bind hpulse_sandcastle_gen hpg_checker #(.CNT_W(CNT_W), .CNT_MAX(CNT_MAX)) u_hpg_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ref_edge(ref_edge),
  .cnt     (line_cnt),
  .run     (line_run),
  .hd_alt  (hd_alt_i),
  .vblank  (vblank_i),
  .hd      (hd_o),
  .gate    (gate_o),
  .hblank  (hblank_o),
  .sc_code (sc_code_o)
);

// File: tb/test_hpulse_sandcastle_gen.sv
module test_hpulse_sandcastle_gen;
  // bench clock-period parameter: 50 ns per tick
  localparam int unsigned TCK_NS = 50;
  localparam int unsigned T_HD   = 1800 / TCK_NS;   // 36
  localparam int unsigned T_G0   = 3000 / TCK_NS;   // 60
  localparam int unsigned T_GW   = 2000 / TCK_NS;   // 40
  localparam int unsigned T_ADV  = 200 / TCK_NS;    // 4
  localparam int unsigned T_B0   = 4400 / TCK_NS;   // 88
  localparam int unsigned T_BW   = 11500 / TCK_NS;  // 230
  localparam int unsigned T_LINE = 70000 / TCK_NS;  // 1400

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic href = 1'b0, hd_alt = 1'b0, gate_adv = 1'b0, vblank = 1'b0;
  logic hd, gate, hblank;
  logic [1:0] sc_code;
  int n_checks = 0, n_errors = 0, cyc = 0;

  always #2.5 clk = ~clk;

  hpulse_sandcastle_gen #(.CLK_PS(TCK_NS * 1000)) i_hpulse_sandcastle_gen (
    .clk(clk), .rst_n(rst_n), .href_i(href), .hd_alt_i(hd_alt),
    .gate_adv_i(gate_adv), .vblank_i(vblank), .hd_o(hd), .gate_o(gate),
    .hblank_o(hblank), .sc_code_o(sc_code));

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // one line: rising reference, then n ticks checked against the timing model
  task automatic run_line(input int n, input logic alt, input logic adv,
                          input logic vb, input logic drop, input string tag);
    hd_alt = alt; gate_adv = adv; vblank = vb;
    if (href) begin @(negedge clk); href = 1'b0; end
    @(negedge clk); href = 1'b1;
    for (int k = 0; k < n; k++) begin
      int g0, kk;
      logic e_hd, e_gt, e_hb;
      @(negedge clk);
      kk = (k > int'(T_LINE)) ? int'(T_LINE) : k;
      g0 = adv ? int'(T_G0 - T_ADV) : int'(T_G0);
      e_hd = alt ? (kk >= int'(T_B0) && kk < int'(T_B0 + T_HD)) : (kk < int'(T_HD));
      e_gt = (kk >= g0) && (kk < g0 + int'(T_GW));
      e_hb = (kk >= int'(T_B0)) && (kk < int'(T_B0 + T_BW));
      check({tag, alt ? " R3" : " R2"}, $sformatf("hd tick %0d", k), int'(hd), int'(e_hd));
      check({tag, adv ? " R5" : " R4"}, $sformatf("gate tick %0d", k), int'(gate), int'(e_gt));
      check({tag, " R6"}, $sformatf("hblank tick %0d", k), int'(hblank), int'(e_hb));
      check({tag, " R7"}, $sformatf("code tick %0d", k), int'(sc_code),
            e_gt ? 3 : e_hb ? 2 : vb ? 1 : 0);
      if (k == 2 && drop) href = 1'b0;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1", "hd after reset", int'(hd), 0);
    check("R1", "gate after reset", int'(gate), 0);
    check("R1", "hblank after reset", int'(hblank), 0);
    check("R1", "code after reset", int'(sc_code), 0);
    vblank = 1'b1;
    @(negedge clk);
    check("R1", "code vblank before ref", int'(sc_code), 1);
    vblank = 1'b0;
  endtask

  task automatic t_normal();   run_line(400, 0, 0, 0, 1, "R11"); endtask
  task automatic t_advance();  run_line(400, 0, 1, 0, 1, "R5");  endtask
  task automatic t_hd_alt();   run_line(400, 1, 0, 0, 1, "R3");  endtask
  task automatic t_vblank();   run_line(400, 1, 1, 1, 1, "R7");  endtask

  task automatic t_early();
    run_line(70, 0, 0, 0, 1, "R8");   // ends inside the gate pulse
    check("R8", "gate active before restart", int'(gate), 1);
    run_line(120, 0, 0, 0, 1, "R8");  // restart truncates gate, re-runs hd
  endtask

  task automatic t_saturate();
    // href held high throughout: no retrigger (R10), no wrap (R9)
    run_line(T_LINE + 200, 0, 0, 0, 0, "R9 R10");
    check("R10", "href still high", int'(href), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_normal();
    t_advance();
    t_hd_alt();
    t_vblank();
    t_early();
    t_saturate();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule